// File: doc/BRIEF.md
# Bank-Interleaved Word Memory

This block is a single-port, word-addressable memory assembled from several identical storage banks. The address is split into two parts. The lower bits give a word offset and go unchanged to every bank. The upper bits pass through a one-hot selector that enables exactly one bank while the memory is enabled. Each bank drives zeros whenever it is not the selected reader, so the bank outputs can be merged onto one read bus with a plain OR.

The default build holds 4096 words of 8 bits in four banks of 1024 words. The bank count, the bank depth and the word width are parameters. One enable input and one direction input choose between idle, store and fetch. A store takes effect at the rising clock edge. Fetched data is registered and appears on the output one clock after the request.

Top module: `bmem_top`

## Requirements
- R1: Address bits [11:10] select the bank: bank k holds addresses k*1024 through k*1024+1023, and address bits [9:0] select the word inside that bank. Storing to each boundary address (0, 1023, 1024, 2047, 2048, 3071, 3072, 4095) and fetching it back returns the value stored there.
- R2: With `mem_en`=1 and `rd_wrn`=0 at a rising edge of `clk`, the word on `din` is stored at `addr`.
- R3: With `mem_en`=1 and `rd_wrn`=1 at a rising edge, `dout` shows the word stored at `addr` from that edge until the next rising edge. This holds for fetches of different addresses on consecutive cycles.
- R4: With `mem_en`=0, no stored word changes, whatever the levels of `rd_wrn`, `din` and `addr`.
- R5: After a rising edge at which the cycle was a store or was idle (`mem_en`=0), `dout` is all zeros.
- R6: A store changes only the selected bank. The word at the same offset in every other bank keeps its value.
- R7: While `rst_n` is low, and after its release until the first fetch, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the read registers |
| mem_en | input | 1 | Memory enable; 0 means no operation |
| rd_wrn | input | 1 | Direction: 1 fetches, 0 stores |
| addr | input | 12 | Word address; upper bits select the bank, lower bits the offset |
| din | input | 8 | Word to store |
| dout | output | 8 | Fetched word, one clock after the request; zero otherwise |

## Verification
The hardest fault to catch from the ports is a store that reaches a bank other than the selected one. A selector that ignores one address bit still returns correct data for any address it stores and then fetches. To expose this, the bench stores different values at the same offset in all four banks. It then overwrites one of them and fetches all four. It also runs disabled cycles that carry a store level, all-ones data and a boundary address, then fetches those words to show they are unchanged.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

   // Operation requested in one cycle, decoded from enable and direction
   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_STORE = 2'b01,
      OP_FETCH = 2'b10
   } bmem_op_e;

   function automatic bmem_op_e bmem_decode_op(input logic en, input logic rd);
      if (!en)
         return OP_IDLE;
      else if (rd)
         return OP_FETCH;
      else
         return OP_STORE;
   endfunction

endpackage

// File: rtl/bmem_bank_sel.sv
module bmem_bank_sel #(
   parameter int NUM_BANKS = 4,
   parameter int SEL_W     = 2
) (
   input  logic                 active,
   input  logic [SEL_W-1:0]     sel,
   output logic [NUM_BANKS-1:0] cs
);

   // One comparator per bank output
   generate
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_cs
         assign cs[k] = active && (sel == SEL_W'(k));
      end
   endgenerate

endmodule

// File: rtl/bmem_bank.sv
module bmem_bank #(
   parameter int WORD_W = 8,
   parameter int BANK_AW = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs,
   input  logic               rd,
   input  logic [BANK_AW-1:0] offs,
   input  logic [WORD_W-1:0]  wdata,
   output logic [WORD_W-1:0]  rdata
);

   localparam int DEPTH = 1 << BANK_AW;

   logic [WORD_W-1:0] store_q [DEPTH];
   logic              wr_go;
   logic              rd_go;

   assign wr_go = cs && !rd;
   assign rd_go = cs && rd;

   always_ff @(posedge clk) begin
      if (wr_go)
         store_q[offs] <= wdata;
   end

   // Registered read port; drives zeros unless this bank served a fetch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_go)
         rdata <= store_q[offs];
      else
         rdata <= '0;
   end

endmodule

// File: rtl/bmem_or_merge.sv
module bmem_or_merge #(
   parameter int NUM_BANKS = 4,
   parameter int WORD_W    = 8
) (
   input  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_q,
   output logic [WORD_W-1:0]                merged
);

   // Chain of OR stages, one per bank
   logic [NUM_BANKS:0][WORD_W-1:0] chain;

   assign chain[0] = '0;

   generate
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_or
         assign chain[k+1] = chain[k] | bank_q[k];
      end
   endgenerate

   assign merged = chain[NUM_BANKS];

endmodule

// File: rtl/bmem_top.sv
module bmem_top #(
   parameter int WORD_W    = 8,
   parameter int BANK_AW   = 10,
   parameter int NUM_BANKS = 4,
   parameter int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   parameter int ADDR_W    = BANK_AW + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_en,
   input  logic              rd_wrn,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);

   import bmem_pkg::*;

   // Parameter checks at elaboration
   generate
      if (NUM_BANKS < 2 || (1 << SEL_W) != NUM_BANKS) begin : g_bad_banks
         $error("bmem_top: NUM_BANKS must be a power of two, at least 2");
      end
      if (ADDR_W != BANK_AW + SEL_W) begin : g_bad_aw
         $error("bmem_top: ADDR_W must equal BANK_AW + SEL_W");
      end
      if (WORD_W < 1 || BANK_AW < 1) begin : g_bad_w
         $error("bmem_top: widths must be positive");
      end
   endgenerate

   bmem_op_e                        op;
   logic [SEL_W-1:0]                bank_idx;
   logic [BANK_AW-1:0]              offs;
   logic [NUM_BANKS-1:0]            cs;
   logic [NUM_BANKS-1:0][WORD_W-1:0] bank_q;

   assign op       = bmem_decode_op(mem_en, rd_wrn);
   assign bank_idx = addr[ADDR_W-1:BANK_AW];
   assign offs     = addr[BANK_AW-1:0];

   bmem_bank_sel #(
      .NUM_BANKS(NUM_BANKS),
      .SEL_W    (SEL_W)
   ) u_sel (
      .active(op != OP_IDLE),
      .sel   (bank_idx),
      .cs    (cs)
   );

   generate
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
         bmem_bank #(
            .WORD_W (WORD_W),
            .BANK_AW(BANK_AW)
         ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .cs   (cs[k]),
            .rd   (op == OP_FETCH),
            .offs (offs),
            .wdata(din),
            .rdata(bank_q[k])
         );
      end
   endgenerate

   bmem_or_merge #(
      .NUM_BANKS(NUM_BANKS),
      .WORD_W   (WORD_W)
   ) u_merge (
      .bank_q(bank_q),
      .merged(dout)
   );

endmodule

// File: rtl/bmem_top_chk.sv
module bmem_top_chk #(
   parameter int WORD_W    = 8,
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mem_en,
   input logic                 rd_wrn,
   input logic [ADDR_W-1:0]    addr,
   input logic [WORD_W-1:0]    dout,
   input logic [NUM_BANKS-1:0] cs
);

   AST_ONE_BANK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> ($countones(cs) == 1)); // R1

   AST_NO_SELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_en |-> (cs == '0)); // R4

   AST_SELECT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs)); // R6

   AST_QUIET_AFTER_NONREAD: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_en && rd_wrn) |=> (dout == '0)); // R5

   AST_REPEAT_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && rd_wrn && $past(mem_en && rd_wrn) && $stable(addr)) |=> $stable(dout)); // R3

   always @(negedge clk) begin
      if (!rst_n)
         AST_RESET_ZERO: assert (dout == '0); // R7
   end

endmodule

bind bmem_top bmem_top_chk #(
   .WORD_W   (WORD_W),
   .NUM_BANKS(NUM_BANKS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .mem_en(mem_en),
   .rd_wrn(rd_wrn),
   .addr  (addr),
   .dout  (dout),
   .cs    (cs)
);

// File: tb/sim_bmem_top.sv
module sim_bmem_top;

   localparam int AW = 12;
   localparam int DW = 8;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mem_en = 1'b0;
   logic          rd_wrn = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;
   logic [DW-1:0] ref_mem [NW];

   always #5 clk = ~clk;

   bmem_top u0 (
      .clk   (clk),
      .rst_n (rst_n),
      .mem_en(mem_en),
      .rd_wrn(rd_wrn),
      .addr  (addr),
      .din   (din),
      .dout  (dout)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: dout=%02h expected %02h at t=%0t", req, act, exp, $time);
      end
   endtask

   // Inputs change at falling edges only
   task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
      mem_en = 1'b1; rd_wrn = 1'b0; addr = a; din = d;
      @(negedge clk);
      ref_mem[a] = d;
      check("R5 store", dout, '0);
   endtask

   task automatic do_fetch(input logic [AW-1:0] a, input string req);
      mem_en = 1'b1; rd_wrn = 1'b1; addr = a; din = '0;
      @(negedge clk);
      check(req, dout, ref_mem[a]);
   endtask

   task automatic do_idle(input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] d);
      mem_en = 1'b0; rd_wrn = rw; addr = a; din = d;
      @(negedge clk);
      check("R5 idle", dout, '0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R7 in reset", dout, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 after release", dout, '0);
   endtask

   task automatic t_boundaries();
      logic [AW-1:0] pts [8] = '{12'd0, 12'd1023, 12'd1024, 12'd2047,
                                 12'd2048, 12'd3071, 12'd3072, 12'd4095};
      for (int i = 0; i < 8; i++)
         do_store(pts[i], DW'(8'h11 * (i + 1)) ^ 8'h5A);
      for (int i = 0; i < 8; i++)
         do_fetch(pts[i], "R1 R2 boundary readback");
   endtask

   task automatic t_same_offset();
      for (int b = 0; b < 4; b++)
         do_store(AW'(b * 1024 + 37), DW'(8'hC0 + b));
      do_store(AW'(2 * 1024 + 37), 8'h3E);
      for (int b = 0; b < 4; b++)
         do_fetch(AW'(b * 1024 + 37), "R6 other banks kept");
   endtask

   task automatic t_disabled();
      do_idle(1'b0, 12'd1024, 8'hFF);
      do_idle(1'b0, 12'd4095, 8'hFF);
      do_idle(1'b1, 12'd0, 8'hFF);
      do_fetch(12'd1024, "R4 no change when disabled");
      do_fetch(12'd4095, "R4 no change when disabled");
      do_fetch(12'd0, "R4 no change when disabled");
      do_idle(1'b1, 12'd0, 8'h00);
   endtask

   task automatic t_stream();
      for (int i = 0; i < 16; i++)
         do_store(AW'(i * 255 + 3), DW'(i * 29 + 7));
      for (int i = 15; i >= 0; i--)
         do_fetch(AW'(i * 255 + 3), "R3 back-to-back fetch");
      do_store(AW'(3), 8'hA5);
      do_fetch(AW'(3), "R2 overwrite");
   endtask

   initial begin
      for (int i = 0; i < NW; i++) ref_mem[i] = 'x;
      t_reset();
      t_boundaries();
      t_same_offset();
      t_disabled();
      t_stream();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule